// File: doc/BRIEF.md
# YUV 4:2:2 Byte-to-Word Packer

This block takes the byte-wide 4:2:2 stream of an image sensor and turns it into 16-bit words ready for a 16-bit memory write. The input carries one byte on every cycle where `byte_vld` is high, inside a window marked by `line_act`. Chroma and luma bytes interleave, so every four bytes describe two pixels. Those two pixels share one U sample and one V sample. A 640-pixel line is therefore 1280 bytes long. The packer joins each luma byte with the chroma byte next to it. It emits one word for every two accepted bytes, and tags the word to say whether its chroma half holds U or V.

The sensor may start a line on either a chroma byte or a luma byte, and that phase can change from line to line. The phase is therefore chosen again at the start of every line. It is never carried over from the line before. A configuration bit gives the phase of the first byte. An optional toggle inverts that choice on every odd line of a frame. A decimation mode keeps every second pixel pair and every second line, which turns a 640x480 frame into 320x240. Byte values pass through unaltered: chroma is offset binary with 128 meaning no colour, and the codes 0 and 255 never occur as data.

The output carries a valid strobe. It also carries start-of-line and start-of-frame markers that are aligned with the first word emitted for a line or a frame. A line that ends with half a pair pending drops that byte and sets a sticky error flag.

Top module: `yuv422_word_packer`

## Requirements
- R1: While reset is asserted, and after it is released until the first word, `out_vld`, `out_sol`, `out_sof` and `out_err` are 0.
- R2: With `cfg_luma_first`=0 (line starts on chroma), the bytes C0 L0 C1 L1 of a line become the words {L0,C0} and then {L1,C1}. `out_data[15:8]` holds luma and `out_data[7:0]` holds chroma.
- R3: With `cfg_luma_first`=1 (line starts on luma), the bytes L0 C0 L1 C1 become the words {L0,C0} and then {L1,C1}, in the same field layout.
- R4: The byte phase restarts at the rising edge of `line_act`, whatever byte ended the previous line. With `cfg_alt_toggle`=1, odd lines use the inverted `cfg_luma_first` selection. Lines are counted from 0 after each `frame_start`.
- R5: A word appears with `out_vld` high in the cycle after its second byte is accepted, and `out_vld` is never high on two consecutive cycles. Bytes are accepted only when `line_act` and `byte_vld` are both high. Gaps in `byte_vld`, and bytes outside `line_act`, do not disturb the pairing.
- R6: `out_sol` is high with the first word emitted for each line. `out_sof` is high only with the first word emitted after a `frame_start` pulse. Both markers are high only together with `out_vld`.
- R7: If `line_act` falls while a single byte of a pair is held, that byte is discarded without producing a word. `out_err` then goes to 1 and stays at 1 until reset.
- R8: With `cfg_decimate`=1, a word is emitted only if bit 1 of its index within the line is 0 (indices 0,1,4,5,…) and the line index within the frame is even. All other words produce no output.
- R9: `out_is_v` is 0 (U) for word index 0 of each line and then alternates U, V, U, V. The count runs over all words of the line, including dropped ones, so the first word of any line is tagged U.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | One-cycle pulse before the first line of a frame, only while `line_act` is low |
| line_act | input | 1 | High while a line's bytes are being delivered |
| byte_vld | input | 1 | `din` holds a byte this cycle |
| din | input | DW (8) | Stream byte |
| cfg_luma_first | input | 1 | 1: a line starts on luma; 0: it starts on chroma |
| cfg_alt_toggle | input | 1 | 1: invert the phase selection on odd lines |
| cfg_decimate | input | 1 | 1: keep every second pair and every second line |
| out_vld | output | 1 | Output word valid |
| out_data | output | 2*DW (16) | {luma, chroma} |
| out_is_v | output | 1 | 0: chroma half is U; 1: it is V |
| out_sol | output | 1 | First word of a line |
| out_sof | output | 1 | First word of a frame |
| out_err | output | 1 | Sticky flag for a dropped partial pair |

## Verification
The assertions assume that `frame_start` only pulses while `line_act` is low. One of them checks this contract directly. They also assume that the configuration inputs stay steady for the whole of a line. The stimulus raises `frame_start` only in the idle gap between lines. It changes the configuration bits only before a frame begins, and it never sends bytes with the reserved values 0 and 255. Under these conditions, the half-rate, marker and sticky-error properties hold for every line the bench sends, including the lines with gaps and the truncated line.

// File: rtl/yuv_pkg.sv
package yuv_pkg;

  // Identity of the chroma half of an output word
  typedef enum logic {
    CHR_U = 1'b0,
    CHR_V = 1'b1
  } chroma_e;

  // Word index bit 0 picks U (even) or V (odd)
  function automatic chroma_e kind_of(input logic idx0);
    return idx0 ? CHR_V : CHR_U;
  endfunction

endpackage

// File: rtl/yuv_phase_track.sv
module yuv_phase_track #(
  parameter int WCW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  input  logic           line_act,
  input  logic           byte_vld,
  input  logic           cfg_luma_first,
  input  logic           cfg_alt_toggle,
  output logic           line_start,
  output logic           first_byte,
  output logic           pair_done,
  output logic           luma_first_eff,
  output logic [WCW-1:0] word_idx,
  output logic           line_odd,
  output logic           err
);

  logic           line_q, line_q_n;
  logic           half_q, half_q_n;
  logic [WCW-1:0] wcnt_q, wcnt_q_n;
  logic           odd_q, odd_q_n;
  logic           err_q, err_q_n;

  logic           line_end;
  logic           half_cur;
  logic           acc;
  logic [WCW-1:0] wcnt_cur;

  // next-state
  always_comb begin
    line_start = line_act & ~line_q;
    line_end   = ~line_act & line_q;
    acc        = line_act & byte_vld;
    half_cur   = line_start ? 1'b0 : half_q;
    wcnt_cur   = line_start ? '0 : wcnt_q;

    first_byte = acc & ~half_cur;
    pair_done  = acc & half_cur;

    line_q_n = line_act;
    if (!line_act)
      half_q_n = 1'b0;
    else if (acc)
      half_q_n = ~half_cur;
    else
      half_q_n = half_cur;

    wcnt_q_n = pair_done ? wcnt_cur + {{(WCW-1){1'b0}}, 1'b1} : wcnt_cur;

    if (frame_start)
      odd_q_n = 1'b0;
    else if (line_end)
      odd_q_n = ~odd_q;
    else
      odd_q_n = odd_q;

    err_q_n = err_q | (line_end & half_q);

    luma_first_eff = cfg_luma_first ^ (cfg_alt_toggle & odd_q);
    word_idx       = wcnt_cur;
    line_odd       = odd_q;
    err            = err_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      half_q <= 1'b0;
      wcnt_q <= '0;
      odd_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      line_q <= line_q_n;
      half_q <= half_q_n;
      wcnt_q <= wcnt_q_n;
      odd_q  <= odd_q_n;
      err_q  <= err_q_n;
    end
  end

  AST_FRAME_OUTSIDE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !line_act); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R7

  AST_DROP_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q && !line_act && half_q) |=> err_q); // R7

endmodule

// File: rtl/yuv_pair_join.sv
module yuv_pair_join
  import yuv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_byte,
  input  logic          luma_first,
  input  logic          idx0,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] luma,
  output logic [DW-1:0] chroma,
  output chroma_e       kind
);

  logic [DW-1:0] held_q, held_q_n;

  // next-state: capture the first byte of each pair
  always_comb begin
    held_q_n = first_byte ? din : held_q;
    if (luma_first) begin
      luma   = held_q;
      chroma = din;
    end else begin
      luma   = din;
      chroma = held_q;
    end
    kind = kind_of(idx0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      held_q <= '0;
    else
      held_q <= held_q_n;
  end

endmodule

// File: rtl/yuv_decim_mark.sv
module yuv_decim_mark
  import yuv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            line_start,
  input  logic            pair_done,
  input  logic            cfg_decimate,
  input  logic            idx1,
  input  logic            line_odd,
  input  logic [DW-1:0]   luma,
  input  logic [DW-1:0]   chroma,
  input  chroma_e         kind,
  output logic            out_vld,
  output logic [2*DW-1:0] out_data,
  output logic            out_is_v,
  output logic            out_sol,
  output logic            out_sof
);

  logic            keep, emit;
  logic            sol_cur, sof_cur;
  logic            sol_q, sol_q_n;
  logic            sof_q, sof_q_n;
  logic            vld_q_n, solo_q_n, sofo_q_n;
  logic [2*DW-1:0] data_q_n;
  logic            isv_q_n;

  // next-state
  always_comb begin
    keep     = ~cfg_decimate | (~idx1 & ~line_odd);
    emit     = pair_done & keep;
    sol_cur  = sol_q | line_start;
    sof_cur  = sof_q | frame_start;
    sol_q_n  = emit ? 1'b0 : sol_cur;
    sof_q_n  = emit ? 1'b0 : sof_cur;
    vld_q_n  = emit;
    solo_q_n = emit & sol_cur;
    sofo_q_n = emit & sof_cur;
    data_q_n = emit ? {luma, chroma} : out_data;
    isv_q_n  = emit ? (kind == CHR_V) : out_is_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sol_q    <= 1'b0;
      sof_q    <= 1'b0;
      out_vld  <= 1'b0;
      out_sol  <= 1'b0;
      out_sof  <= 1'b0;
      out_data <= '0;
      out_is_v <= 1'b0;
    end else begin
      sol_q    <= sol_q_n;
      sof_q    <= sof_q_n;
      out_vld  <= vld_q_n;
      out_sol  <= solo_q_n;
      out_sof  <= sofo_q_n;
      out_data <= data_q_n;
      out_is_v <= isv_q_n;
    end
  end

  AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld); // R5

  AST_SOL_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_sol |-> out_vld); // R6

  AST_SOF_NEEDS_SOL: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_sol); // R6

  AST_SOL_TAG_U: assert property (@(posedge clk) disable iff (!rst_n)
    out_sol |-> !out_is_v); // R9

endmodule

// File: rtl/yuv422_word_packer.sv
module yuv422_word_packer
  import yuv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            line_act,
  input  logic            byte_vld,
  input  logic [DW-1:0]   din,
  input  logic            cfg_luma_first,
  input  logic            cfg_alt_toggle,
  input  logic            cfg_decimate,
  output logic            out_vld,
  output logic [2*DW-1:0] out_data,
  output logic            out_is_v,
  output logic            out_sol,
  output logic            out_sof,
  output logic            out_err
);

  localparam int WCW = 2;  // word index bits: bit0 = U/V, bit1 = pair parity

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic           line_start, first_byte, pair_done, luma_first_eff, line_odd;
  logic [WCW-1:0] word_idx;
  logic [DW-1:0]  luma, chroma;
  chroma_e        kind;

  yuv_phase_track #(.WCW(WCW)) u_phase (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .frame_start    (frame_start),
    .line_act       (line_act),
    .byte_vld       (byte_vld),
    .cfg_luma_first (cfg_luma_first),
    .cfg_alt_toggle (cfg_alt_toggle),
    .line_start     (line_start),
    .first_byte     (first_byte),
    .pair_done      (pair_done),
    .luma_first_eff (luma_first_eff),
    .word_idx       (word_idx),
    .line_odd       (line_odd),
    .err            (out_err)
  );

  yuv_pair_join #(.DW(DW)) u_join (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .first_byte (first_byte),
    .luma_first (luma_first_eff),
    .idx0       (word_idx[0]),
    .din        (din),
    .luma       (luma),
    .chroma     (chroma),
    .kind       (kind)
  );

  yuv_decim_mark #(.DW(DW)) u_dec (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .frame_start  (frame_start),
    .line_start   (line_start),
    .pair_done    (pair_done),
    .cfg_decimate (cfg_decimate),
    .idx1         (word_idx[1]),
    .line_odd     (line_odd),
    .luma         (luma),
    .chroma       (chroma),
    .kind         (kind),
    .out_vld      (out_vld),
    .out_data     (out_data),
    .out_is_v     (out_is_v),
    .out_sol      (out_sol),
    .out_sof      (out_sof)
  );

endmodule

// File: tb/sim_yuv422_word_packer.sv
`timescale 1ns/1ps
module sim_yuv422_word_packer;

  logic        clk = 1'b0;
  logic        rst_n, frame_start, line_act, byte_vld;
  logic [7:0]  din;
  logic        cfg_luma_first, cfg_alt_toggle, cfg_decimate;
  logic        out_vld, out_is_v, out_sol, out_sof, out_err;
  logic [15:0] out_data;

  always #4 clk = ~clk;  // 125 MHz

  yuv422_word_packer u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_act(line_act),
    .byte_vld(byte_vld), .din(din), .cfg_luma_first(cfg_luma_first),
    .cfg_alt_toggle(cfg_alt_toggle), .cfg_decimate(cfg_decimate),
    .out_vld(out_vld), .out_data(out_data), .out_is_v(out_is_v),
    .out_sol(out_sol), .out_sof(out_sof), .out_err(out_err)
  );

  // table: line-start phase, 8 input bytes (first byte in MSBs), 4 expected words
  localparam int NV = 4;
  localparam logic        VLF [NV] = '{1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [63:0] VIN [NV] = '{
    64'h80108020_80308040, 64'h01FE7F02_C35A819B,
    64'h10802080_30704090, 64'hA55A33CC_01FE7E81};
  localparam logic [63:0] VEXP [NV] = '{
    64'h1080_2080_3080_4080, 64'hFE01_027F_5AC3_9B81,
    64'h1080_2080_3070_4090, 64'hA55A_33CC_01FE_7E81};

  int checks = 0, fails = 0, cap_n = 0, cyc = 0;
  logic [15:0] cw [64];
  bit ct [64], cs [64], cf [64];
  bit prev_vld = 0, consec = 0, done = 0;
  logic [7:0] lb [32];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (out_vld === 1'b1 && cap_n < 64) begin
      cw[cap_n] = out_data; ct[cap_n] = out_is_v;
      cs[cap_n] = out_sol;  cf[cap_n] = out_sof;
      cap_n++;
    end
    if (out_vld === 1'b1 && prev_vld) consec = 1;
    prev_vld = (out_vld === 1'b1);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic pulse_frame;
    frame_start = 1'b1; tick; frame_start = 1'b0; tick;
  endtask

  task automatic send_line(input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      line_act = 1'b1; byte_vld = 1'b1; din = lb[i]; tick;
      if (gap) begin byte_vld = 1'b0; din = 8'h55; tick; end
    end
    line_act = 1'b0; byte_vld = 1'b0; din = 8'h00;
    repeat (4) tick;
  endtask

  initial begin
    rst_n = 1'b0; frame_start = 0; line_act = 0; byte_vld = 0; din = 0;
    cfg_luma_first = 0; cfg_alt_toggle = 0; cfg_decimate = 0;
    repeat (3) tick;
    // R1: reset state
    chk(out_vld === 1'b0, "R1", "out_vld in reset", int'(out_vld), 0);
    chk(out_err === 1'b0, "R1", "out_err in reset", int'(out_err), 0);
    chk(out_sol === 1'b0 && out_sof === 1'b0, "R1", "markers in reset",
        int'({out_sol, out_sof}), 0);
    rst_n = 1'b1;
    repeat (4) tick;
    chk(out_vld === 1'b0 && out_err === 1'b0, "R1", "after release",
        int'({out_vld, out_err}), 0);

    // R2 R3 R9 R6: table walk, one frame of one line per vector
    for (int e = 0; e < NV; e++) begin
      cfg_luma_first = VLF[e];
      pulse_frame;
      for (int i = 0; i < 8; i++) lb[i] = VIN[e][63-8*i -: 8];
      cap_n = 0;
      send_line(8, 0);
      chk(cap_n == 4, VLF[e] ? "R3" : "R2", "word count", cap_n, 4);
      for (int k = 0; k < 4; k++) begin
        chk(cw[k] == VEXP[e][63-16*k -: 16], VLF[e] ? "R3" : "R2", "word",
            int'(cw[k]), int'(VEXP[e][63-16*k -: 16]));
        chk(ct[k] == k[0], "R9", "U/V tag", int'(ct[k]), int'(k[0]));
        chk(cs[k] == (k == 0) && cf[k] == (k == 0), "R6", "markers",
            int'({cs[k], cf[k]}), (k == 0) ? 3 : 0);
      end
    end

    // R5: timing of one word, then gaps and bytes outside line_act
    cfg_luma_first = 0;
    pulse_frame;
    cap_n = 0;
    line_act = 1; byte_vld = 1; din = 8'h80; tick;
    din = 8'h42; tick;
    line_act = 1; byte_vld = 0;
    @(negedge clk);
    chk(out_vld === 1'b1 && out_data == 16'h4280, "R5", "word one cycle after 2nd byte",
        int'(out_data), 16'h4280);
    tick; line_act = 0; repeat (3) tick;
    chk(cap_n == 1, "R5", "single word", cap_n, 1);

    pulse_frame;
    line_act = 0; byte_vld = 1; din = 8'h33; repeat (3) tick;
    byte_vld = 0;
    for (int i = 0; i < 8; i++) lb[i] = VIN[1][63-8*i -: 8];
    cap_n = 0; consec = 0;
    send_line(8, 1);
    chk(cap_n == 4, "R5", "count with gaps", cap_n, 4);
    for (int k = 0; k < 4; k++)
      chk(cw[k] == VEXP[1][63-16*k -: 16], "R5", "word with gaps",
          int'(cw[k]), int'(VEXP[1][63-16*k -: 16]));
    chk(consec == 0, "R5", "no back-to-back valid", int'(consec), 0);

    // R4: alternate-line toggle
    cfg_luma_first = 0; cfg_alt_toggle = 1;
    pulse_frame;
    cap_n = 0;
    lb[0] = 8'h10; lb[1] = 8'h20; lb[2] = 8'h30; lb[3] = 8'h40; send_line(4, 0);
    lb[0] = 8'h50; lb[1] = 8'h60; lb[2] = 8'h70; lb[3] = 8'h80; send_line(4, 0);
    lb[0] = 8'h11; lb[1] = 8'h22; lb[2] = 8'h33; lb[3] = 8'h44; send_line(4, 0);
    chk(cap_n == 6, "R4", "words over three lines", cap_n, 6);
    chk(cw[0] == 16'h2010 && cw[1] == 16'h4030, "R4", "line0 chroma first",
        int'(cw[1]), 16'h4030);
    chk(cw[2] == 16'h5060 && cw[3] == 16'h7080, "R4", "line1 inverted to luma first",
        int'(cw[3]), 16'h7080);
    chk(cw[4] == 16'h2211 && cw[5] == 16'h4433, "R4", "line2 chroma first",
        int'(cw[5]), 16'h4433);
    chk(cs[0] && cs[2] && cs[4] && !cs[1] && !cs[3] && !cs[5], "R6", "sol per line",
        int'({cs[0], cs[2], cs[4]}), 7);
    chk(cf[0] && !cf[2] && !cf[4], "R6", "sof once per frame",
        int'({cf[0], cf[2], cf[4]}), 4);
    cfg_alt_toggle = 0;

    // R8: decimation
    cfg_decimate = 1;
    pulse_frame;
    for (int i = 0; i < 16; i++) lb[i] = 8'(8'h20 + i);
    cap_n = 0;
    send_line(16, 0);
    chk(cap_n == 4, "R8", "even line kept words", cap_n, 4);
    chk(cw[0] == 16'h2120 && cw[1] == 16'h2322 && cw[2] == 16'h2928 && cw[3] == 16'h2B2A,
        "R8", "kept word values", int'(cw[2]), 16'h2928);
    chk(!ct[0] && ct[1] && !ct[2] && ct[3], "R9", "tags in decimation",
        int'({ct[0], ct[1], ct[2], ct[3]}), 5);
    send_line(16, 0);
    chk(cap_n == 4, "R8", "odd line dropped", cap_n, 4);
    send_line(16, 0);
    chk(cap_n == 8 && cw[4] == 16'h2120, "R8", "third line kept", cap_n, 8);
    chk(cs[4] && !cf[4] && cf[0], "R6", "markers in decimation",
        int'({cs[4], cf[4], cf[0]}), 5);
    cfg_decimate = 0;

    // R7 + R4: truncated line then phase restart
    pulse_frame;
    chk(out_err === 1'b0, "R7", "err clear before", int'(out_err), 0);
    cap_n = 0;
    lb[0] = 8'h11; lb[1] = 8'h22; lb[2] = 8'h33; lb[3] = 8'h44; lb[4] = 8'h55;
    send_line(5, 0);
    chk(cap_n == 2, "R7", "partial pair discarded", cap_n, 2);
    chk(out_err === 1'b1, "R7", "err set", int'(out_err), 1);
    lb[0] = 8'h66; lb[1] = 8'h77; lb[2] = 8'h88; lb[3] = 8'h99;
    send_line(4, 0);
    chk(cap_n == 4 && cw[2] == 16'h7766 && cw[3] == 16'h9988, "R4",
        "phase restarts after odd line", int'(cw[2]), 16'h7766);
    chk(out_err === 1'b1, "R7", "err sticky", int'(out_err), 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule